// File: doc/BRIEF.md
# Flash Write Protection Guard

This block decides, one request at a time, whether a serial flash may change its array or its status bits. The array is 128K x 8, split into four 32 KB blocks. A two-bit protect field marks the upper blocks of the array as read-only. Each program, region erase or whole-array erase request gets a registered grant or deny, together with a mask of the blocks that may actually be written. A whole-array erase skips the locked blocks and erases only the free ones.

Status-register writes follow the chip-enable frame. The request opens a pending write. It is judged when chip-enable rises, and it passes only if exactly one data byte was seen. A stored enable bit decides whether the active-low protect pin can block the write. If the pin goes low at any time in the frame, the write is cancelled. Once the internal status cycle has begun, the pin no longer has any effect. Command shifting, the array and erase timing live in neighbouring logic.

Top module: `flash_wp_guard`

## Requirements
- R1: Out of reset, every grant, deny and busy output is 0 and the block mask is all zero.
- R2: For requests of kind 2'b00 (program) and 2'b01 (region erase), the target block is address bits [16:15]. The protect field locks blocks as follows: 00 none, 01 block 3, 10 blocks 2 and 3, 11 all blocks. On the cycle after the request, a free block gives a grant with a one-hot mask of that block, and a locked block gives a deny.
- R3: A request of kind 2'b10 (whole-array erase) grants with a mask of all unlocked blocks. It denies when all four blocks are locked.
- R4: A status write (kind 2'b11) is denied when the enable bit is 1 and the protect pin is low at any cycle between the request and the chip-enable rising edge, including that edge.
- R5: When the enable bit is 0, the protect pin has no effect on status writes.
- R6: A status write is denied unless exactly one data-byte strobe arrived while the frame was open.
- R7: A status request is taken only while chip-enable is low. It is judged at the chip-enable rising edge, and the grant or deny pulse appears for one cycle on the clock after that edge. A grant sets busy in the same cycle.
- R8: While busy, changes on the protect pin do not clear busy. Only the done input clears it.
- R9: While busy, any array request is denied, and a status request gives a status deny pulse on the next cycle.
- R10: Grant and deny are never high together on either channel, and a denied array request leaves the mask at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bp_i | input | 2 | Stored block-protect field |
| wpen_i | input | 1 | Stored enable bit for the protect pin |
| wp_n_i | input | 1 | Active-low write-protect pin |
| cs_n_i | input | 1 | Active-low chip enable |
| addr_i | input | 17 | Target byte address |
| req_i | input | 1 | Request strobe |
| req_kind_i | input | 2 | 00 program, 01 region erase, 10 whole erase, 11 status write |
| sts_byte_i | input | 1 | One status data byte received |
| sts_done_i | input | 1 | Internal status cycle finished |
| arr_grant_o | output | 1 | Array request granted |
| arr_deny_o | output | 1 | Array request refused |
| blk_mask_o | output | 4 | Blocks the granted request may change |
| sts_grant_o | output | 1 | Status write committed |
| sts_deny_o | output | 1 | Status write refused |
| sts_busy_o | output | 1 | Internal status cycle running |

## Verification
Two things can meet in the same cycle: the protect pin falling and the chip-enable rising edge that commits a status write. The bench lowers the pin in exactly the commit cycle and expects a deny. It lowers the pin one cycle later and expects a grant, with busy holding until done. A short low pulse on the pin in mid-frame, released before the edge, must still deny. The same commit sequences run with the enable bit clear, where every one of them is expected to grant.

// File: rtl/flash_wp_guard.sv
module flash_wp_guard #(
  parameter int ADDR_W = 17,
  parameter int BLK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bp_i,
  input  logic              wpen_i,
  input  logic              wp_n_i,
  input  logic              cs_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              req_i,
  input  logic [1:0]        req_kind_i,
  input  logic              sts_byte_i,
  input  logic              sts_done_i,
  output logic              arr_grant_o,
  output logic              arr_deny_o,
  output logic [(1<<BLK_W)-1:0] blk_mask_o,
  output logic              sts_grant_o,
  output logic              sts_deny_o,
  output logic              sts_busy_o
);
  localparam int NBLK = 1 << BLK_W;
  localparam logic [1:0] K_CHIP = 2'b10;
  localparam logic [1:0] K_STS  = 2'b11;

  function automatic logic [NBLK-1:0] lock_of(input logic [1:0] bp);
    logic [NBLK-1:0] m;
    for (int i = 0; i < NBLK; i++) begin
      case (bp)
        2'b01:   m[i] = (i >= NBLK - NBLK/4);
        2'b10:   m[i] = (i >= NBLK/2);
        2'b11:   m[i] = 1'b1;
        default: m[i] = 1'b0;
      endcase
    end
    return m;
  endfunction

  logic [NBLK-1:0]  locked, tgt_hot, free_mask;
  logic [BLK_W-1:0] tgt;
  logic             arr_req, arr_ok;
  logic             unused_lo;

  assign unused_lo = ^addr_i[ADDR_W-BLK_W-1:0];
  assign locked    = lock_of(bp_i);
  assign tgt       = addr_i[ADDR_W-1 -: BLK_W];
  assign tgt_hot   = NBLK'(1) << tgt;
  assign arr_req   = req_i && req_kind_i != K_STS;
  assign free_mask = (req_kind_i == K_CHIP) ? ~locked : (tgt_hot & ~locked);
  assign arr_ok    = arr_req && !sts_busy_o && (|free_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_grant_o <= 1'b0;
      arr_deny_o  <= 1'b0;
      blk_mask_o  <= '0;
    end else begin
      arr_grant_o <= arr_ok;
      arr_deny_o  <= arr_req && !arr_ok;
      blk_mask_o  <= arr_ok ? free_mask : '0;
    end
  end

  logic       cs_q, pending, cancel;
  logic [1:0] nbytes;
  logic       cs_rise, sts_req, sts_start, wp_block, commit_ok, commit_bad;

  assign cs_rise    = !cs_q && cs_n_i;
  assign sts_req    = req_i && req_kind_i == K_STS;
  assign sts_start  = sts_req && !cs_n_i && !sts_busy_o && !pending;
  assign wp_block   = wpen_i && !wp_n_i;
  assign commit_ok  = pending && cs_rise && !cancel && !wp_block && nbytes == 2'd1;
  assign commit_bad = pending && cs_rise && !commit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 1'b1;
      pending     <= 1'b0;
      cancel      <= 1'b0;
      nbytes      <= 2'd0;
      sts_grant_o <= 1'b0;
      sts_deny_o  <= 1'b0;
      sts_busy_o  <= 1'b0;
    end else begin
      cs_q <= cs_n_i;
      if (cs_rise) pending <= 1'b0;
      else if (sts_start) pending <= 1'b1;
      if (sts_start) begin
        cancel <= wp_block;
        nbytes <= 2'd0;
      end else if (pending && !cs_n_i) begin
        cancel <= cancel || wp_block;
        if (sts_byte_i && nbytes != 2'd2) nbytes <= nbytes + 2'd1;
      end
      sts_grant_o <= commit_ok;
      sts_deny_o  <= commit_bad || (sts_req && sts_busy_o);
      if (commit_ok) sts_busy_o <= 1'b1;
      else if (sts_done_i) sts_busy_o <= 1'b0;
    end
  end
endmodule

module flash_wp_guard_chk #(
  parameter int ADDR_W = 17,
  parameter int BLK_W  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic [1:0] bp_i,
  input logic cs_n_i,
  input logic req_i,
  input logic [1:0] req_kind_i,
  input logic sts_done_i,
  input logic arr_grant_o,
  input logic arr_deny_o,
  input logic [(1<<BLK_W)-1:0] blk_mask_o,
  input logic sts_grant_o,
  input logic sts_deny_o,
  input logic sts_busy_o
);
  assert_arr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_grant_o && arr_deny_o));
  assert_sts_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_grant_o && sts_deny_o));
  assert_deny_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_deny_o |-> blk_mask_o == '0);
  assert_grant_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant_o |-> $countones(blk_mask_o) >= 1);
  assert_all_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && req_kind_i != 2'b11 && bp_i == 2'b11) |=> arr_deny_o);
  assert_grant_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_grant_o |-> (sts_busy_o && $past(cs_n_i)));
  assert_busy_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_busy_o) |-> sts_grant_o);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_busy_o && !sts_done_i) |=> sts_busy_o);
  assert_busy_arr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_busy_o && req_i && req_kind_i != 2'b11) |=> arr_deny_o);
endmodule

bind flash_wp_guard flash_wp_guard_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (.*);

// File: tb/flash_wp_guard_bench.sv
module flash_wp_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bp_i = 2'b00;
  logic wpen_i = 1'b0, wp_n_i = 1'b1, cs_n_i = 1'b1;
  logic [16:0] addr_i = '0;
  logic req_i = 1'b0;
  logic [1:0] req_kind_i = 2'b00;
  logic sts_byte_i = 1'b0, sts_done_i = 1'b0;
  logic arr_grant_o, arr_deny_o, sts_grant_o, sts_deny_o, sts_busy_o;
  logic [3:0] blk_mask_o;
  int total = 0, bad = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  flash_wp_guard u_flash_wp_guard (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_locks(input logic [1:0] bp);
    case (bp)
      2'b01: return 4'b1000;
      2'b10: return 4'b1100;
      2'b11: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] exp_mask(input logic [1:0] bp, input logic [16:0] a, input logic [1:0] k);
    logic [3:0] hot;
    hot = 4'b0001 << a[16:15];
    return (k == 2'b10) ? ~exp_locks(bp) : (hot & ~exp_locks(bp));
  endfunction

  task automatic arr_try(input logic [1:0] bp, input logic [16:0] a, input logic [1:0] k, input string tag);
    logic [3:0] m;
    @(negedge clk);
    bp_i = bp; addr_i = a; req_kind_i = k; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    m = exp_mask(bp, a, k);
    chk(arr_grant_o == (m != 0) && arr_deny_o == (m == 0) && blk_mask_o == m,
        tag, {arr_grant_o, arr_deny_o, blk_mask_o}, {m != 0, m == 0, m});
  endtask

  // phase: 0 none, 1 low at request, 2 low pulse mid-frame, 3 low at rise, 4 low after rise
  task automatic sts_try(input bit wpen, input int phase, input int nb, input string tag);
    bit exp_ok;
    exp_ok = (nb == 1) && !(wpen && phase >= 1 && phase <= 3);
    @(negedge clk);
    wpen_i = wpen; cs_n_i = 1'b0; req_kind_i = 2'b11; req_i = 1'b1;
    wp_n_i = (phase == 1) ? 1'b0 : 1'b1;
    @(negedge clk);
    req_i = 1'b0; wp_n_i = 1'b1;
    for (int b = 0; b < nb; b++) begin
      sts_byte_i = 1'b1; @(negedge clk); sts_byte_i = 1'b0; @(negedge clk);
    end
    if (phase == 2) begin
      wp_n_i = 1'b0; @(negedge clk); wp_n_i = 1'b1; @(negedge clk);
    end
    cs_n_i = 1'b1;
    if (phase == 3) wp_n_i = 1'b0;
    @(negedge clk);
    chk(sts_grant_o == exp_ok && sts_deny_o == !exp_ok && sts_busy_o == exp_ok,
        tag, {sts_grant_o, sts_deny_o, sts_busy_o}, {exp_ok, !exp_ok, exp_ok});
    if (phase == 4) wp_n_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sts_grant_o == 0 && sts_busy_o == exp_ok, {tag, " R8 hold"}, sts_busy_o, exp_ok);
    wp_n_i = 1'b1;
    sts_done_i = 1'b1; @(negedge clk); sts_done_i = 1'b0;
    chk(sts_busy_o == 0, {tag, " R8 done"}, sts_busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    chk(!arr_grant_o && !arr_deny_o && blk_mask_o == 0 && !sts_grant_o && !sts_deny_o && !sts_busy_o,
        "R1 reset", {arr_grant_o, arr_deny_o, blk_mask_o, sts_grant_o, sts_deny_o, sts_busy_o}, 0);
    rst_n = 1'b1;
    // R2 block edges
    arr_try(2'b01, 17'h17FFF, 2'b00, "R2 bp01 below");
    arr_try(2'b01, 17'h18000, 2'b00, "R2 bp01 block3");
    arr_try(2'b10, 17'h0FFFF, 2'b01, "R2 bp10 block1");
    arr_try(2'b10, 17'h10000, 2'b01, "R2 bp10 block2");
    arr_try(2'b11, 17'h00000, 2'b00, "R2 bp11 block0");
    arr_try(2'b00, 17'h1FFFF, 2'b00, "R2 bp00 top");
    // R3 whole erase
    for (int b = 0; b < 4; b++) arr_try(b[1:0], 17'h0, 2'b10, "R3 chip erase");
    for (int i = 0; i < 300; i++)
      arr_try(2'($urandom_range(0, 3)), 17'($urandom_range(0, 17'h1FFFF)),
              2'($urandom_range(0, 2)), "R2 R3 random");
    // status frames
    sts_try(1'b0, 0, 1, "R7 plain grant");
    sts_try(1'b1, 1, 1, "R4 low at request");
    sts_try(1'b1, 2, 1, "R4 mid pulse");
    sts_try(1'b1, 3, 1, "R4 low at rise");
    sts_try(1'b1, 4, 1, "R8 low after rise");
    sts_try(1'b0, 1, 1, "R5 pin ignored start");
    sts_try(1'b0, 3, 1, "R5 pin ignored rise");
    sts_try(1'b0, 0, 0, "R6 no byte");
    sts_try(1'b0, 0, 2, "R6 two bytes");
    for (int i = 0; i < 40; i++)
      sts_try(1'($urandom_range(0, 1)), int'($urandom_range(0, 4)), int'($urandom_range(0, 2)), "R4 R6 random");
    // R7 request with chip-enable high is not taken
    @(negedge clk); req_kind_i = 2'b11; req_i = 1'b1; cs_n_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(!sts_grant_o && !sts_deny_o && !sts_busy_o, "R7 cs high ignored", sts_busy_o, 0);
    // R9 requests while busy
    @(negedge clk); wpen_i = 0; cs_n_i = 0; req_kind_i = 2'b11; req_i = 1;
    @(negedge clk); req_i = 0; sts_byte_i = 1;
    @(negedge clk); sts_byte_i = 0; cs_n_i = 1;
    @(negedge clk);
    chk(sts_busy_o == 1, "R9 setup busy", sts_busy_o, 1);
    bp_i = 2'b00; addr_i = 17'h0; req_kind_i = 2'b00; req_i = 1;
    @(negedge clk); req_i = 0;
    chk(arr_deny_o && !arr_grant_o && blk_mask_o == 0, "R9 array while busy", {arr_grant_o, arr_deny_o}, 1);
    cs_n_i = 0; req_kind_i = 2'b11; req_i = 1;
    @(negedge clk); req_i = 0; cs_n_i = 1;
    chk(sts_deny_o && !sts_grant_o && sts_busy_o, "R9 status while busy", {sts_grant_o, sts_deny_o}, 1);
    @(negedge clk);
    chk(!sts_grant_o && !sts_deny_o, "R9 no late commit", {sts_grant_o, sts_deny_o}, 0);
    sts_done_i = 1; @(negedge clk); sts_done_i = 0;
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule